// File: doc/BRIEF.md
# Oscillator Steering Holdover Controller

This block sits between a disciplining loop filter and the tuning actuator of a local oscillator. The loop filter proposes a steering word every cycle. The controller decides whether that word may reach the actuator, based on whether a satellite timing reference is present, a severity level from an integrity monitor, a pulse-jump flag and the measured phase residual. It runs a six-state machine. While the reference is trusted it passes or slowly tracks the word. When trust is lost it freezes the word or drifts it slowly. When the reference returns it walks the word back toward the request in limited steps each second, so the actuator never sees a jump.

Alongside the word it reports several things. It gives a mode code, a locked flag and a time-valid flag. It keeps a count of holdover seconds and a holdover grade from 3 down to 0 that drops as the outage lengthens. It gives a time-error estimate equal to a slope times the elapsed holdover seconds, and a headroom alarm for a word close to either actuator rail. Each state change is announced by a one-cycle event carrying the old and new mode codes. Seconds are marked by a one-cycle `sec_tick` strobe from the surrounding timebase.

Top module: `steer_holdover_ctrl`

## Requirements
- R1: While reset is held, and just after it, the outputs take their idle values: mode 0, steering word at the centre of the actuator range ((STEER_MIN+STEER_MAX)/2, 32767 by default), grade 0, locked 0, time-valid 0, holdover seconds 0, event low. Mode codes are: 0 waiting for reference, 1 disciplining, 2 settled, 3 reference lost, 4 holdover, 5 recovery.
- R2: The reference counts as good when it is present, severity is below 2 and no pulse jump is flagged. From mode 0 the controller moves to mode 1 on the first cycle the reference is good and stays in mode 0 otherwise. In modes 1 and 2 at severity 0, the steering word equals the clamped request one cycle later.
- R3: The requested word is clamped to [STEER_MIN, STEER_MAX] (1024 and 64511 by default). The headroom alarm is high exactly when the applied word lies less than the margin input away from either rail.
- R4: At severity 1 in modes 1 and 2, the word moves only on a second tick, by (target - word) arithmetically shifted right by SLOW_SHIFT (default 2).
- R5: A bad reference in mode 1, 2 or 5 moves the controller to mode 3 on the next cycle. Mode 3 always leads to mode 4 on the following cycle. The word does not move during mode 3.
- R6: In mode 4 with the policy input at 0, the word is frozen whatever the request. With the policy input at 1, it takes the same reduced step as R4 on each tick.
- R7: The holdover second count reads 0 in the first holdover cycle. It rises by one per tick in mode 4, saturating at its maximum. The grade in mode 4 is 3 below GRADE_T2 seconds (4), 2 below GRADE_T1 (8), 1 below GRADE_T0 (16), and 0 from then on. The grade is 3 in mode 2 and 0 in all other modes.
- R8: The time-error estimate is the slope input times the holdover seconds, doubled while severity is 3, and saturated at 2^TE_W-1 (TE_W default 20).
- R9: Mode 4 is left only for mode 5, and only when the reference is good. In mode 5, each tick moves the word toward the target by at most the step-limit input. Once the word equals the target, the next cycle returns to mode 1.
- R10: In mode 1, SETTLE_N (default 3) ticks in a row with |residual| no larger than the bound input lead to mode 2. A tick with a larger residual in mode 2 returns to mode 1. Locked is high only in mode 2.
- R11: Time-valid is high only in mode 2, or in mode 4 with a non-zero grade.
- R12: Every change of mode raises the event output for exactly the first cycle of the new mode, with the previous and new mode codes alongside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| ref_present | input | 1 | Satellite timing reference is available |
| sev_level | input | 2 | Integrity severity, 0 to 3 |
| pps_jump | input | 1 | Pulse phase jump detected |
| phase_resid | input | RES_W | Signed measured phase residual |
| steer_req | input | STEER_W | Steering word proposed by the loop filter |
| cfg_slow_policy | input | 1 | Holdover policy: 0 freeze, 1 slow steer |
| cfg_step_max | input | STEER_W | Largest word change per tick in recovery |
| cfg_settle_bound | input | RES_W | Residual bound for settling |
| cfg_te_slope | input | SLOPE_W | Time-error growth per holdover second |
| cfg_margin | input | STEER_W | Rail distance that raises the headroom alarm |
| steer_out | output | STEER_W | Word applied to the actuator |
| mode | output | 3 | Current mode code |
| locked | output | 1 | Settled |
| time_valid | output | 1 | Time output may be trusted |
| grade | output | 2 | Holdover grade, 3 best |
| hold_secs | output | HOLD_W | Elapsed holdover seconds |
| te_est | output | TE_W | Time-error estimate |
| headroom_alarm | output | 1 | Word near an actuator rail |
| evt_valid | output | 1 | One-cycle mode-change event |
| evt_old | output | 3 | Mode before the change |
| evt_new | output | 3 | Mode after the change |

## Verification
The hardest situation to reach is a late holdover. The grade must have decayed to zero, the time-error product must be at its saturation edge, and the frozen word must still be held while the request wanders. Only then does the reference come back, so that recovery must walk a known distance in limited steps. The stimulus gets there in one continuous sequence. It settles the loop with small residuals, forces a loss with a pulse jump, and clocks sixteen seconds of holdover while raising the slope and severity to straddle the saturation point. Then it switches to slow steer for one tick and restores the reference with a small step limit, so each intermediate word of the recovery ramp can be predicted.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_DISC    = 3'd1,
    ST_SETTLED = 3'd2,
    ST_LOST    = 3'd3,
    ST_HOLD    = 3'd4,
    ST_RECOV   = 3'd5
  } mode_e;
endpackage

// File: rtl/steer_fsm.sv
module steer_fsm
  import steer_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int SETTLE_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             ref_good,
  input  logic [RES_W-1:0] phase_resid,
  input  logic [RES_W-1:0] cfg_settle_bound,
  input  logic             at_target,
  output mode_e            st,
  output logic             evt_valid,
  output logic [2:0]       evt_old,
  output logic [2:0]       evt_new
);
  localparam int CW = $clog2(SETTLE_N + 1);

  function automatic logic [RES_W-1:0] abs_res(input logic [RES_W-1:0] r);
    return r[RES_W-1] ? (~r + 1'b1) : r;
  endfunction

  mode_e           nxt;
  logic [CW-1:0]   settle_cnt;
  logic            in_bound;

  assign in_bound = abs_res(phase_resid) <= cfg_settle_bound;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_WAIT:    if (ref_good) nxt = ST_DISC;
      ST_DISC:    if (!ref_good) nxt = ST_LOST;
                  else if (sec_tick && in_bound && settle_cnt == CW'(SETTLE_N - 1)) nxt = ST_SETTLED;
      ST_SETTLED: if (!ref_good) nxt = ST_LOST;
                  else if (sec_tick && !in_bound) nxt = ST_DISC;
      ST_LOST:    nxt = ST_HOLD;
      ST_HOLD:    if (ref_good) nxt = ST_RECOV;
      ST_RECOV:   if (!ref_good) nxt = ST_LOST;
                  else if (at_target) nxt = ST_DISC;
      default:    nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_WAIT;
      settle_cnt <= '0;
      evt_valid  <= 1'b0;
      evt_old    <= 3'd0;
      evt_new    <= 3'd0;
    end else begin
      st        <= nxt;
      evt_valid <= (nxt != st);
      evt_old   <= st;
      evt_new   <= nxt;
      if (st != ST_DISC) settle_cnt <= '0;
      else if (sec_tick) settle_cnt <= in_bound ? settle_cnt + 1'b1 : '0;
    end
  end

  assert_lost_on_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DISC || st == ST_SETTLED || st == ST_RECOV) && !ref_good) |=> st == ST_LOST);
  assert_lost_to_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_LOST |=> st == ST_HOLD);
  assert_hold_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !ref_good) |=> st == ST_HOLD);
  assert_event_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_new == st && evt_old != evt_new));
  assert_event_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> evt_valid);
endmodule

// File: rtl/steer_actuator.sv
module steer_actuator
  import steer_pkg::*;
#(
  parameter int STEER_W    = 16,
  parameter int STEER_MIN  = 1024,
  parameter int STEER_MAX  = 64511,
  parameter int SLOW_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mode_e              st,
  input  logic               sec_tick,
  input  logic               ref_good,
  input  logic [1:0]         sev_level,
  input  logic [STEER_W-1:0] steer_req,
  input  logic               cfg_slow_policy,
  input  logic [STEER_W-1:0] cfg_step_max,
  input  logic [STEER_W-1:0] cfg_margin,
  output logic [STEER_W-1:0] steer_out,
  output logic               at_target,
  output logic               headroom_alarm
);
  localparam int DW = STEER_W + 2;
  localparam logic [STEER_W-1:0] LO  = STEER_W'(STEER_MIN);
  localparam logic [STEER_W-1:0] HI  = STEER_W'(STEER_MAX);
  localparam logic [STEER_W-1:0] MID = STEER_W'((STEER_MIN + STEER_MAX) / 2);

  function automatic logic [STEER_W-1:0] clamp_word(input logic [STEER_W-1:0] w);
    if (w < LO) return LO;
    if (w > HI) return HI;
    return w;
  endfunction

  function automatic logic signed [DW-1:0] slow_step(input logic signed [DW-1:0] d);
    return d >>> SLOW_SHIFT;
  endfunction

  function automatic logic signed [DW-1:0] limit_step(input logic signed [DW-1:0] d,
                                                      input logic [STEER_W-1:0] m);
    logic signed [DW-1:0] mm;
    mm = $signed({2'b00, m});
    if (d > mm) return mm;
    if (d < -mm) return -mm;
    return d;
  endfunction

  function automatic logic [STEER_W-1:0] absdiff(input logic [STEER_W-1:0] a,
                                                 input logic [STEER_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic [STEER_W-1:0]    target;
  logic signed [DW-1:0]  diff, step, sum;

  assign target    = clamp_word(steer_req);
  assign diff      = $signed({2'b00, target}) - $signed({2'b00, steer_out});
  assign at_target = (steer_out == target);
  assign headroom_alarm = ((steer_out - LO) < cfg_margin) || ((HI - steer_out) < cfg_margin);

  always_comb begin
    step = '0;
    unique case (st)
      ST_DISC, ST_SETTLED:
        if (ref_good) begin
          if (sev_level == 2'd1) step = sec_tick ? slow_step(diff) : '0;
          else step = diff;
        end
      ST_HOLD:  if (cfg_slow_policy && sec_tick) step = slow_step(diff);
      ST_RECOV: if (ref_good && sec_tick) step = limit_step(diff, cfg_step_max);
      default:  step = '0;
    endcase
  end

  assign sum = $signed({2'b00, steer_out}) + step;

  always_ff @(posedge clk) begin
    if (!rst_n) steer_out <= MID;
    else        steer_out <= sum[STEER_W-1:0];
  end

  assert_in_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    steer_out >= LO && steer_out <= HI);
  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == ST_HOLD && !cfg_slow_policy) |-> $stable(steer_out));
  assert_lost_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == ST_LOST) |-> $stable(steer_out));
  assert_recov_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == ST_RECOV) |-> absdiff(steer_out, $past(steer_out)) <= $past(cfg_step_max));
endmodule

// File: rtl/hold_report.sv
module hold_report
  import steer_pkg::*;
#(
  parameter int HOLD_W   = 16,
  parameter int SLOPE_W  = 16,
  parameter int TE_W     = 20,
  parameter int GRADE_T2 = 4,
  parameter int GRADE_T1 = 8,
  parameter int GRADE_T0 = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mode_e              st,
  input  logic               sec_tick,
  input  logic [1:0]         sev_level,
  input  logic [SLOPE_W-1:0] cfg_te_slope,
  output logic [HOLD_W-1:0]  hold_secs,
  output logic [1:0]         grade,
  output logic [TE_W-1:0]    te_est,
  output logic               time_valid,
  output logic               locked
);
  localparam int PW = SLOPE_W + HOLD_W + 1;
  localparam logic [HOLD_W-1:0] HOLD_MAX = '1;
  localparam logic [TE_W-1:0]   TE_MAX   = '1;

  function automatic logic [TE_W-1:0] te_calc(input logic [SLOPE_W-1:0] k,
                                              input logic [HOLD_W-1:0] t,
                                              input logic wide);
    logic [PW-1:0] p;
    p = PW'(k) * PW'(t);
    if (wide) p = p << 1;
    if (p > PW'(TE_MAX)) return TE_MAX;
    return p[TE_W-1:0];
  endfunction

  function automatic logic [1:0] hold_grade(input logic [HOLD_W-1:0] t);
    if (t < HOLD_W'(GRADE_T2)) return 2'd3;
    if (t < HOLD_W'(GRADE_T1)) return 2'd2;
    if (t < HOLD_W'(GRADE_T0)) return 2'd1;
    return 2'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) hold_secs <= '0;
    else if (st == ST_HOLD) begin
      if (sec_tick && hold_secs != HOLD_MAX) hold_secs <= hold_secs + 1'b1;
    end else if (st != ST_RECOV) hold_secs <= '0;
  end

  always_comb begin
    unique case (st)
      ST_HOLD:    grade = hold_grade(hold_secs);
      ST_SETTLED: grade = 2'd3;
      default:    grade = 2'd0;
    endcase
  end

  assign te_est     = te_calc(cfg_te_slope, hold_secs, sev_level == 2'd3);
  assign locked     = (st == ST_SETTLED);
  assign time_valid = locked || (st == ST_HOLD && grade != 2'd0);

  assert_hold_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == ST_HOLD) && st == ST_HOLD) |-> hold_secs >= $past(hold_secs));
  assert_grade_decay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == ST_HOLD) && st == ST_HOLD) |-> grade <= $past(grade));
  assert_time_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |-> (locked || st == ST_HOLD));
endmodule

// File: rtl/steer_holdover_ctrl.sv
module steer_holdover_ctrl
  import steer_pkg::*;
#(
  parameter int STEER_W    = 16,
  parameter int STEER_MIN  = 1024,
  parameter int STEER_MAX  = 64511,
  parameter int SLOW_SHIFT = 2,
  parameter int RES_W      = 16,
  parameter int SETTLE_N   = 3,
  parameter int HOLD_W     = 16,
  parameter int SLOPE_W    = 16,
  parameter int TE_W       = 20,
  parameter int GRADE_T2   = 4,
  parameter int GRADE_T1   = 8,
  parameter int GRADE_T0   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               ref_present,
  input  logic [1:0]         sev_level,
  input  logic               pps_jump,
  input  logic [RES_W-1:0]   phase_resid,
  input  logic [STEER_W-1:0] steer_req,
  input  logic               cfg_slow_policy,
  input  logic [STEER_W-1:0] cfg_step_max,
  input  logic [RES_W-1:0]   cfg_settle_bound,
  input  logic [SLOPE_W-1:0] cfg_te_slope,
  input  logic [STEER_W-1:0] cfg_margin,
  output logic [STEER_W-1:0] steer_out,
  output logic [2:0]         mode,
  output logic               locked,
  output logic               time_valid,
  output logic [1:0]         grade,
  output logic [HOLD_W-1:0]  hold_secs,
  output logic [TE_W-1:0]    te_est,
  output logic               headroom_alarm,
  output logic               evt_valid,
  output logic [2:0]         evt_old,
  output logic [2:0]         evt_new
);
  mode_e st;
  logic  ref_good;
  logic  at_target;

  assign ref_good = ref_present && (sev_level < 2'd2) && !pps_jump;
  assign mode     = st;

  steer_fsm #(.RES_W(RES_W), .SETTLE_N(SETTLE_N)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_good(ref_good),
    .phase_resid(phase_resid), .cfg_settle_bound(cfg_settle_bound),
    .at_target(at_target), .st(st), .evt_valid(evt_valid),
    .evt_old(evt_old), .evt_new(evt_new)
  );

  steer_actuator #(.STEER_W(STEER_W), .STEER_MIN(STEER_MIN), .STEER_MAX(STEER_MAX),
                   .SLOW_SHIFT(SLOW_SHIFT)) u_act (
    .clk(clk), .rst_n(rst_n), .st(st), .sec_tick(sec_tick), .ref_good(ref_good),
    .sev_level(sev_level), .steer_req(steer_req), .cfg_slow_policy(cfg_slow_policy),
    .cfg_step_max(cfg_step_max), .cfg_margin(cfg_margin), .steer_out(steer_out),
    .at_target(at_target), .headroom_alarm(headroom_alarm)
  );

  hold_report #(.HOLD_W(HOLD_W), .SLOPE_W(SLOPE_W), .TE_W(TE_W), .GRADE_T2(GRADE_T2),
                .GRADE_T1(GRADE_T1), .GRADE_T0(GRADE_T0)) u_rep (
    .clk(clk), .rst_n(rst_n), .st(st), .sec_tick(sec_tick), .sev_level(sev_level),
    .cfg_te_slope(cfg_te_slope), .hold_secs(hold_secs), .grade(grade),
    .te_est(te_est), .time_valid(time_valid), .locked(locked)
  );
endmodule

// File: tb/steer_holdover_ctrl_bench.sv
module steer_holdover_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick, ref_present, pps_jump, cfg_slow_policy;
  logic [1:0]  sev_level;
  logic [15:0] phase_resid, steer_req, cfg_step_max, cfg_settle_bound, cfg_te_slope, cfg_margin;
  logic [15:0] steer_out, hold_secs;
  logic [2:0]  mode, evt_old, evt_new;
  logic        locked, time_valid, headroom_alarm, evt_valid;
  logic [1:0]  grade;
  logic [19:0] te_est;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  steer_holdover_ctrl u_steer_holdover_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_present(ref_present),
    .sev_level(sev_level), .pps_jump(pps_jump), .phase_resid(phase_resid),
    .steer_req(steer_req), .cfg_slow_policy(cfg_slow_policy), .cfg_step_max(cfg_step_max),
    .cfg_settle_bound(cfg_settle_bound), .cfg_te_slope(cfg_te_slope), .cfg_margin(cfg_margin),
    .steer_out(steer_out), .mode(mode), .locked(locked), .time_valid(time_valid),
    .grade(grade), .hold_secs(hold_secs), .te_est(te_est), .headroom_alarm(headroom_alarm),
    .evt_valid(evt_valid), .evt_old(evt_old), .evt_new(evt_new)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic tick(); sec_tick = 1'b1; cyc(); sec_tick = 1'b0; cyc(); endtask

  function automatic longint slow_exp(input longint cur, input longint tgt);
    return cur + ((tgt - cur) >>> 2);
  endfunction

  task automatic t_reset_R1();
    rst_n = 0; sec_tick = 0; ref_present = 0; pps_jump = 0; sev_level = 0;
    cfg_slow_policy = 0; phase_resid = 0; steer_req = 16'd40000; cfg_step_max = 16'd30;
    cfg_settle_bound = 16'd50; cfg_te_slope = 16'd1000; cfg_margin = 16'd256;
    repeat (3) cyc();
    chk("R1 mode", mode, 0);
    chk("R1 steer", steer_out, 32767);
    chk("R1 grade", grade, 0);
    chk("R1 flags", {locked, time_valid, evt_valid}, 0);
    chk("R1 hold", hold_secs, 0);
    rst_n = 1; cyc();
    chk("R2 stays waiting without reference", mode, 0);
  endtask

  task automatic t_enter_disc_R2();
    ref_present = 1; cyc();
    chk("R2 mode disc", mode, 1);
    chk("R12 event", {evt_valid, evt_old, evt_new}, {1'b1, 3'd0, 3'd1});
    cyc();
    chk("R2 follows request", steer_out, 40000);
    chk("R12 event one cycle", evt_valid, 0);
  endtask

  task automatic t_clamp_R3();
    steer_req = 16'd100; cyc();
    chk("R3 low clamp", steer_out, 1024);
    chk("R3 alarm low", headroom_alarm, 1);
    steer_req = 16'hFFFF; cyc();
    chk("R3 high clamp", steer_out, 64511);
    chk("R3 alarm high", headroom_alarm, 1);
    steer_req = 16'd1324; cyc();
    chk("R3 no alarm at margin", headroom_alarm, 0);
    steer_req = 16'd1200; cyc();
    chk("R3 alarm inside margin", headroom_alarm, 1);
  endtask

  task automatic t_reduced_bw_R4();
    longint e;
    steer_req = 16'd40000; phase_resid = 16'd1000; cyc();
    sev_level = 1; steer_req = 16'd40400; cyc();
    chk("R4 no move without tick", steer_out, 40000);
    tick(); e = slow_exp(40000, 40400);
    chk("R4 slow step up", steer_out, e);
    tick(); e = slow_exp(e, 40400);
    chk("R4 slow step up 2", steer_out, e);
    steer_req = 16'd40000; tick(); e = slow_exp(e, 40000);
    chk("R4 slow step down", steer_out, e);
    chk("R4 still disciplining", mode, 1);
  endtask

  task automatic t_settle_R10();
    sev_level = 0; steer_req = 16'd40000; phase_resid = 16'd10; cyc();
    tick(); tick();
    chk("R10 not yet settled", mode, 1);
    tick();
    chk("R10 settled", mode, 2);
    chk("R10 locked", locked, 1);
    chk("R11 valid when settled", time_valid, 1);
    chk("R7 grade settled", grade, 3);
    phase_resid = 16'hFF9C; tick();
    chk("R10 residual out of bound", mode, 1);
    chk("R10 unlocked", locked, 0);
    phase_resid = 16'hFFF6; tick(); tick(); tick();
    chk("R10 settled again with negative residual", mode, 2);
  endtask

  task automatic t_holdover_R6();
    pps_jump = 1; cyc();
    chk("R5 lost on jump", mode, 3);
    chk("R12 event lost", {evt_valid, evt_old, evt_new}, {1'b1, 3'd2, 3'd3});
    pps_jump = 0; ref_present = 0; cyc();
    chk("R5 lost to hold", mode, 4);
    chk("R5 word held", steer_out, 40000);
    chk("R7 hold starts at zero", hold_secs, 0);
    chk("R11 valid in graded hold", time_valid, 1);
    steer_req = 16'd50000;
    tick(); tick(); tick();
    chk("R7 grade 3 at 3 s", grade, 3);
    tick();
    chk("R7 grade 2 at 4 s", grade, 2);
    tick();
    chk("R6 frozen word", steer_out, 40000);
    chk("R7 hold seconds", hold_secs, 5);
    chk("R8 estimate", te_est, 5000);
    sev_level = 3; cyc();
    chk("R8 widened at severity 3", te_est, 10000);
    chk("R9 stays in hold at severity 3", mode, 4);
    sev_level = 0;
    for (int i = 0; i < 11; i++) tick();
    chk("R7 hold 16 s", hold_secs, 16);
    chk("R7 grade 0", grade, 0);
    chk("R11 invalid at grade 0", time_valid, 0);
    chk("R8 estimate 16 s", te_est, 16000);
    cfg_te_slope = 16'hFFFF; cyc();
    chk("R8 below saturation", te_est, 65535 * 16);
    sev_level = 3; cyc();
    chk("R8 saturated", te_est, (1 << 20) - 1);
    sev_level = 0; cfg_te_slope = 16'd1000;
    cfg_slow_policy = 1; steer_req = 16'd40400; tick();
    chk("R6 slow steer in hold", steer_out, slow_exp(40000, 40400));
  endtask

  task automatic t_recovery_R9();
    ref_present = 1; steer_req = 16'd40200; cyc();
    chk("R9 recovery entered", mode, 5);
    chk("R12 event recovery", {evt_valid, evt_old, evt_new}, {1'b1, 3'd4, 3'd5});
    chk("R11 invalid in recovery", time_valid, 0);
    tick();
    chk("R9 limited step 1", steer_out, 40130);
    tick();
    chk("R9 limited step 2", steer_out, 40160);
    tick(); tick();
    chk("R9 final step reaches target", steer_out, 40200);
    chk("R9 back to disciplining", mode, 1);
    cyc();
    chk("R7 hold cleared after recovery", hold_secs, 0);
    sev_level = 2; cyc();
    chk("R5 lost on severity 2", mode, 3);
    cyc();
    chk("R5 hold after severity 2", mode, 4);
    chk("R7 hold zero at new outage", hold_secs, 0);
  endtask

  initial begin
    t_reset_R1();
    t_enter_disc_R2();
    t_clamp_R3();
    t_reduced_bw_R4();
    t_settle_R10();
    t_holdover_R6();
    t_recovery_R9();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule